// File: doc/BRIEF.md
# Memory Zero-Fill and Checkerboard Self-Test Sequencer

This block takes over a single-port sample memory of 2^ADDR_W rows whenever a maintenance sweep is running. A sweep either clears every row to zero or writes an alternating checkerboard into every row and then reads each row back to confirm the contents. Four control inputs steer it: a zero request, a zero cancel, a test start pulse and a pattern choice. A word-clock tick input enforces a rest interval between back-to-back zero sweeps.

Outside a sweep, the host's read and write requests pass straight through to the memory. During a sweep those requests are dropped. A zero sweep is sticky: once it begins it finishes on its own, and only the cancel input can stop it early. A self-test cannot be stopped at all. Leaving reset always begins a zero sweep. The status outputs report idle/ready, busy, the result of the last self-test, and the pending self-test bit, which clears itself when the test ends.

Top module: `maint_sweep_ctrl`

## Requirements
- R1: Leaving reset begins a zero sweep. Busy is high and ready is low. The sweep writes 0 to rows 0 through 2^ADDR_W-1, one row per clock, and busy stays high for exactly 2^ADDR_W cycles.
- R2: A zero request held for a single clock produces a complete zero sweep covering every row.
- R3: While the zero request stays high, a new zero sweep begins once the rest interval after the previous sweep has ended. Once the request is low, no new zero sweep begins.
- R4: After a zero sweep completes, no new zero sweep begins until a wc_tick pulse has been seen. During that wait, ready stays high and busy stays low.
- R5: A high zero_cancel ends a running zero sweep at the next clock edge, and rows not yet reached keep their contents. While zero_cancel is high, no zero sweep begins, whatever the state of the zero request.
- R6: The checkerboard value depends on the row and on pat_sel. With pat_sel=1, even rows hold 0x2AAA and odd rows hold 0x1555. With pat_sel=0, even rows hold 0x1555 and odd rows hold 0x2AAA. These values are the low 14 bits of the alternating masks.
- R7: A self-test writes all rows and then reads all rows. Busy stays high for 2*2^ADDR_W+1 cycles. When the test ends, pass is 1 if every read matched and 0 otherwise, and pass changes at no other time.
- R8: test_set raises test_bit, which falls by itself when the self-test ends. zero_cancel has no effect on a running self-test.
- R9: While busy is high, host writes are discarded and host reads never raise host_rvalid.
- R10: While idle, a host write stores host_wdata at host_addr. A host read raises host_rvalid one clock later, with the row contents on host_rdata.
- R11: If a zero sweep and a self-test are both eligible to begin in the same clock, the zero sweep runs first and the self-test follows.
- R12: Out of reset, pass and test_bit are 0. Ready falls when a sweep begins and rises when the sweep completes or is cancelled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| zero_req | input | 1 | Zero-sweep request level |
| zero_cancel | input | 1 | Aborts a zero sweep and blocks new ones |
| test_set | input | 1 | Pulse that requests a self-test |
| pat_sel | input | 1 | Checkerboard phase choice, latched at test start |
| wc_tick | input | 1 | Word-clock tick, one cycle wide |
| host_rd_req | input | 1 | Host read request |
| host_wr_req | input | 1 | Host write request |
| host_addr | input | ADDR_W | Host row address |
| host_wdata | input | DATA_W | Host write data |
| host_rdata | output | DATA_W | Host read data |
| host_rvalid | output | 1 | host_rdata valid |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | ADDR_W | Memory row address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data, one clock after the read |
| ready | output | 1 | No sweep running; last sweep finished or cancelled |
| busy | output | 1 | Sweep running |
| pass | output | 1 | Result of the last self-test |
| test_bit | output | 1 | Self-test pending or running |

## Verification
The bench builds the block with ADDR_W=4 and DATA_W=14. This gives 16-row sweeps: a zero sweep lasts 16 cycles and a self-test lasts 33. At that size every row can be read back after each sweep, and sweep lengths can be counted to the exact cycle. DATA_W=14 keeps the checkerboard values at 0x2AAA and 0x1555. A memory model with an injectable bit fault lets the bench see pass fall to 0.

// File: rtl/maint_pkg.sv
package maint_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ZERO,
    ST_TWR,
    ST_TRD,
    ST_DRN
  } mst_e;

  // Alternating-bit word; row parity XOR phase picks which mask
  function automatic logic [31:0] ckb_word(input logic row_odd, input logic sel);
    return (row_odd ^ sel) ? 32'hAAAA_AAAA : 32'h5555_5555;
  endfunction

endpackage

// File: rtl/sweep_counter.sv
module sweep_counter #(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          step,
  output logic [AW-1:0] row,
  output logic          at_end
);
  localparam logic [AW-1:0] LAST_ROW = '1;

  always_ff @(posedge clk) begin
    if (!rst_n)    row <= '0;
    else if (clr)  row <= '0;
    else if (step) row <= row + AW'(1);
  end

  assign at_end = (row == LAST_ROW);

  AST_SWEEP_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !clr && at_end) |=> (row == '0)); // R1

endmodule

// File: rtl/wc_holdoff.sv
module wc_holdoff (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic tick,
  output logic hold
);
  always_ff @(posedge clk) begin
    if (!rst_n)    hold <= 1'b0;
    else if (arm)  hold <= 1'b1;
    else if (tick) hold <= 1'b0;
  end

  AST_HOLD_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && !tick) |=> hold); // R4

endmodule

// File: rtl/ckb_checker.sv
module ckb_checker #(
  parameter int DW = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          cmp_en,
  input  logic [DW-1:0] exp_word,
  input  logic [DW-1:0] got_word,
  output logic          fail_any
);
  logic miss_now;
  logic sticky_q;

  assign miss_now = cmp_en && (got_word != exp_word);

  always_ff @(posedge clk) begin
    if (!rst_n)     sticky_q <= 1'b0;
    else if (clear) sticky_q <= 1'b0;
    else            sticky_q <= sticky_q | miss_now;
  end

  assign fail_any = sticky_q | miss_now;

  AST_MISS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (sticky_q && !clear) |=> sticky_q); // R7

endmodule

// File: rtl/maint_sweep_ctrl.sv
module maint_sweep_ctrl
  import maint_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              zero_req,
  input  logic              zero_cancel,
  input  logic              test_set,
  input  logic              pat_sel,
  input  logic              wc_tick,
  input  logic              host_rd_req,
  input  logic              host_wr_req,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic              host_rvalid,
  output logic              mem_en,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              ready,
  output logic              busy,
  output logic              pass,
  output logic              test_bit
);

  mst_e st_q, st_d;
  logic [ADDR_W-1:0] row;
  logic row_end;
  logic hold;
  logic fail_any;

  logic sel_q, test_bit_q, ready_q, pass_q, rvalid_q;
  logic cmp_en_q;
  logic [DATA_W-1:0] exp_q;
  logic [DATA_W-1:0] pat_word;

  // Named events for assertions
  logic test_req, start_zero, start_test, zero_abort, zero_done, test_done;
  logic sw_wr, sw_rd, host_go, step;

  assign test_req   = test_bit_q | test_set;
  assign start_zero = (st_q == ST_IDLE) && zero_req && !zero_cancel && !hold;
  assign start_test = (st_q == ST_IDLE) && test_req && !start_zero;
  assign zero_abort = (st_q == ST_ZERO) && zero_cancel;
  assign zero_done  = (st_q == ST_ZERO) && !zero_cancel && row_end;
  assign test_done  = (st_q == ST_DRN);

  assign sw_wr   = ((st_q == ST_ZERO) && !zero_cancel) || (st_q == ST_TWR);
  assign sw_rd   = (st_q == ST_TRD);
  assign host_go = (st_q == ST_IDLE) && (host_rd_req || host_wr_req);
  assign step    = (st_q == ST_ZERO) || (st_q == ST_TWR) || (st_q == ST_TRD);
  assign busy    = (st_q != ST_IDLE);

  assign pat_word = DATA_W'(ckb_word(row[0], sel_q));

  sweep_counter #(.AW(ADDR_W)) u_sweep (
    .clk(clk), .rst_n(rst_n), .clr(start_zero | start_test), .step(step),
    .row(row), .at_end(row_end)
  );

  wc_holdoff u_hold (
    .clk(clk), .rst_n(rst_n), .arm(zero_done), .tick(wc_tick), .hold(hold)
  );

  ckb_checker #(.DW(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .clear(start_test), .cmp_en(cmp_en_q),
    .exp_word(exp_q), .got_word(mem_rdata), .fail_any(fail_any)
  );

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: begin
        if (start_zero)      st_d = ST_ZERO;
        else if (start_test) st_d = ST_TWR;
      end
      ST_ZERO: if (zero_cancel || row_end) st_d = ST_IDLE;
      ST_TWR:  if (row_end) st_d = ST_TRD;
      ST_TRD:  if (row_end) st_d = ST_DRN;
      ST_DRN:  st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_comb begin
    mem_en    = sw_wr || sw_rd || host_go;
    mem_we    = sw_wr || ((st_q == ST_IDLE) && host_wr_req);
    mem_addr  = busy ? row : host_addr;
    mem_wdata = host_wdata;
    if (st_q == ST_ZERO)     mem_wdata = '0;
    else if (st_q == ST_TWR) mem_wdata = pat_word;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q       <= ST_ZERO;
      sel_q      <= 1'b0;
      test_bit_q <= 1'b0;
      ready_q    <= 1'b0;
      pass_q     <= 1'b0;
      rvalid_q   <= 1'b0;
      cmp_en_q   <= 1'b0;
      exp_q      <= '0;
    end else begin
      st_q     <= st_d;
      rvalid_q <= (st_q == ST_IDLE) && host_rd_req && !host_wr_req;
      cmp_en_q <= sw_rd;
      exp_q    <= pat_word;
      if (start_test) sel_q <= pat_sel;
      if (test_set)       test_bit_q <= 1'b1;
      else if (test_done) test_bit_q <= 1'b0;
      if (start_zero || start_test)             ready_q <= 1'b0;
      else if (zero_done || zero_abort || test_done) ready_q <= 1'b1;
      if (test_done) pass_q <= !fail_any;
    end
  end

  assign host_rdata  = mem_rdata;
  assign host_rvalid = rvalid_q;
  assign ready       = ready_q;
  assign pass        = pass_q;
  assign test_bit    = test_bit_q;

  AST_ZERO_WRITES_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_ZERO) && mem_we) |-> (mem_wdata == '0)); // R1
  AST_CANCEL_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    zero_cancel |=> (st_q != ST_ZERO)); // R5
  AST_HOLD_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> (st_q != ST_ZERO)); // R4
  AST_TWR_NO_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_TWR) |=> (st_q == ST_TWR || st_q == ST_TRD)); // R8
  AST_TRD_NO_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_TRD) |=> (st_q == ST_TRD || st_q == ST_DRN)); // R8
  AST_TESTBIT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(test_bit_q) |-> ready_q); // R8
  AST_HOST_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && host_rd_req) |=> !host_rvalid); // R9
  AST_PASS_ONLY_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pass_q) |-> $past(st_q == ST_DRN)); // R7

endmodule

// File: tb/maint_sweep_ctrl_tb_top.sv
module maint_sweep_ctrl_tb_top;
  localparam int AW = 4;
  localparam int DW = 14;
  localparam int NROW = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic zero_req = 0, zero_cancel = 0, test_set = 0, pat_sel = 0, wc_tick = 0;
  logic host_rd_req = 0, host_wr_req = 0;
  logic [AW-1:0] host_addr = '0;
  logic [DW-1:0] host_wdata = '0;
  logic [DW-1:0] host_rdata;
  logic host_rvalid, mem_en, mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic [DW-1:0] mem_rdata = '0;
  logic ready, busy, pass, test_bit;

  logic [DW-1:0] mem [NROW];
  logic fault_on = 1'b0;
  logic [AW-1:0] fault_row = '0;

  int n_tests = 0;
  int n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  maint_sweep_ctrl #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .zero_req(zero_req), .zero_cancel(zero_cancel),
    .test_set(test_set), .pat_sel(pat_sel), .wc_tick(wc_tick),
    .host_rd_req(host_rd_req), .host_wr_req(host_wr_req), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .host_rvalid(host_rvalid),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .ready(ready), .busy(busy), .pass(pass), .test_bit(test_bit)
  );

  // Memory model with optional bit-0 fault on one row
  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) mem[mem_addr] <= (fault_on && mem_addr == fault_row) ? (mem_wdata ^ 14'h1) : mem_wdata;
      else        mem_rdata <= mem[mem_addr];
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int exp_ckb(input int r, input bit sel);
    return (((r % 2) == 0) == sel) ? 14'h2AAA : 14'h1555;
  endfunction

  task automatic host_write(input int a, input int d);
    @(negedge clk);
    host_wr_req = 1; host_addr = AW'(a); host_wdata = DW'(d);
    @(negedge clk);
    host_wr_req = 0;
  endtask

  task automatic host_read(input int a, output int d, output bit v);
    @(negedge clk);
    host_rd_req = 1; host_addr = AW'(a);
    @(negedge clk);
    host_rd_req = 0;
    d = int'(host_rdata); v = host_rvalid;
  endtask

  task automatic tick();
    @(negedge clk); wc_tick = 1;
    @(negedge clk); wc_tick = 0;
  endtask

  task automatic count_busy(output int n);
    n = 0;
    while (busy && n < 1000) begin n++; @(negedge clk); end
  endtask

  task automatic t_reset();
    int n, d, bad; bit v;
    repeat (4) @(negedge clk);
    rst_n = 1;
    chk("R1 busy after reset", busy, 1);
    chk("R12 ready after reset", ready, 0);
    chk("R12 pass after reset", pass, 0);
    chk("R12 test_bit after reset", test_bit, 0);
    count_busy(n);
    chk("R1 reset zero length", n, NROW);
    chk("R12 ready after sweep", ready, 1);
    bad = 0;
    for (int r = 0; r < NROW; r++) begin host_read(r, d, v); if (d != 0) bad++; end
    chk("R1 rows zero after reset", bad, 0);
  endtask

  task automatic t_host();
    int d; bit v;
    host_write(3, 14'h1ABC);
    host_read(3, d, v);
    chk("R10 host readback", d, 14'h1ABC);
    chk("R10 host rvalid", v, 1);
    @(negedge clk);
    chk("R10 rvalid drops", host_rvalid, 0);
  endtask

  task automatic t_sticky();
    int n, d; bit v;
    host_write(9, 14'h0777);
    tick();
    @(negedge clk); zero_req = 1;
    @(negedge clk); zero_req = 0;
    count_busy(n);
    chk("R2 one-clock request full sweep", n, NROW);
    host_read(9, d, v);
    chk("R2 row cleared", d, 0);
  endtask

  task automatic t_hold_repeat();
    int n;
    @(negedge clk); zero_req = 1;
    repeat (6) @(negedge clk);
    chk("R4 no restart before tick busy", busy, 0);
    chk("R4 ready during hold", ready, 1);
    tick();
    @(negedge clk);
    chk("R3 restart after tick", busy, 1);
    count_busy(n);
    chk("R3 repeated sweep length", n, NROW - 1 + 1);
    zero_req = 0;
    tick();
    repeat (3) @(negedge clk);
    chk("R3 no sweep once request low", busy, 0);
  endtask

  task automatic t_cancel();
    int d; bit v;
    host_write(15, 14'h0555);
    tick();
    @(negedge clk); zero_req = 1;
    repeat (3) @(negedge clk);
    zero_cancel = 1;
    @(negedge clk);
    chk("R5 cancel stops sweep", busy, 0);
    chk("R12 ready after cancel", ready, 1);
    tick();
    repeat (3) @(negedge clk);
    chk("R5 cancel blocks new sweep", busy, 0);
    zero_cancel = 0; zero_req = 0;
    host_read(15, d, v);
    chk("R5 unswept row kept", d, 14'h0555);
    host_read(0, d, v);
    chk("R5 swept row zero", d, 0);
  endtask

  task automatic t_ignore();
    int d; bit v;
    host_write(1, 14'h0011);
    tick();
    @(negedge clk); zero_req = 1;
    @(negedge clk); zero_req = 0;
    repeat (6) @(negedge clk);
    chk("R9 still busy", busy, 1);
    host_write(1, 14'h0ABC);
    host_read(1, d, v);
    chk("R9 read blocked no rvalid", v, 0);
    while (busy) @(negedge clk);
    host_read(1, d, v);
    chk("R9 write during sweep dropped", d, 0);
  endtask

  task automatic run_test(input bit sel, input bit cancel, input string req, input int exp_pass);
    int n, d, bad; bit v;
    @(negedge clk); test_set = 1; pat_sel = sel;
    @(negedge clk); test_set = 0;
    chk("R8 test_bit raised", test_bit, 1);
    if (cancel) zero_cancel = 1;
    count_busy(n);
    zero_cancel = 0;
    chk("R7 test length", n, 2 * NROW + 1);
    chk(req, pass, exp_pass);
    chk("R8 test_bit self-clears", test_bit, 0);
    bad = 0;
    for (int r = 0; r < NROW; r++) begin
      host_read(r, d, v);
      if (!(fault_on && r == int'(fault_row)) && d != exp_ckb(r, sel)) bad++;
    end
    chk("R6 checkerboard contents", bad, 0);
  endtask

  task automatic t_prio();
    int n;
    tick();
    @(negedge clk); zero_req = 1; test_set = 1; pat_sel = 1;
    @(negedge clk); zero_req = 0; test_set = 0;
    count_busy(n);
    chk("R11 zero sweep first", n, NROW);
    chk("R11 test still pending", test_bit, 1);
    @(negedge clk);
    count_busy(n);
    chk("R11 test follows", n, 2 * NROW + 1);
    chk("R11 pass after deferred test", pass, 1);
  endtask

  initial begin
    for (int r = 0; r < NROW; r++) mem[r] = DW'(r * 5 + 3);
    t_reset();
    t_host();
    t_sticky();
    t_hold_repeat();
    t_cancel();
    t_ignore();
    run_test(1'b1, 1'b0, "R7 pass sel1", 1);
    run_test(1'b0, 1'b1, "R8 cancel ignored pass sel0", 1);
    fault_on = 1; fault_row = 4'd6;
    run_test(1'b1, 1'b0, "R7 fault gives fail", 0);
    fault_on = 0;
    run_test(1'b1, 1'b0, "R7 pass recovers", 1);
    t_prio();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule